// File: doc/BRIEF.md
# ROM and SRAM Combo Memory Sequencer

This block lets a clocked host use an asynchronous combo memory device that holds a 512K x8 read-only region and a 32K x8 static RAM region behind one address bus and one byte-wide data bus. The host raises a one-cycle request. The request carries a region flag, a read/write flag, a 19-bit address and a write byte. The sequencer then steps the device pins through the cycle shape that fits the region. When the access completes it pulses `done`, and for reads it presents the captured byte on `rd_data`.

The device has a ROM chip select and one shared pin. For ROM accesses the shared pin acts as the output enable. For RAM accesses it acts as the RAM chip select. The sequencer never lets the two meanings overlap. Every time interval is a clock count, taken as the ceiling of a nanosecond minimum divided by the clock period. Each of these times is a module parameter.

Top module: `combo_mem_ctrl`

## Requirements
- R1: Out of reset, and whenever no access is running, `rom_sel_n`, `shr_sel_n` and `wr_en_n` are high and `bus_oe` is low; `rd_data`, `done` and `err` reset to 0.
- R2: A ROM access (`req_ram`=0) drives the full 19-bit address and `rom_sel_n` low for one setup cycle with `shr_sel_n` high. It then holds `shr_sel_n` low for ACT_RD cycles with `rom_sel_n` still low. The read/write flag is ignored, so `wr_en_n` stays high.
- R3: A RAM read (`req_ram`=1, `req_wr`=0) keeps `rom_sel_n` high, drives address bits 18..15 as 0, and holds `shr_sel_n` low and `wr_en_n` high for ACT_RD cycles after a one-cycle setup.
- R4: A RAM write lowers `shr_sel_n` and `wr_en_n` together for ACT_WR cycles after a one-cycle setup. During that time the address is held steady and `bus_dout` carries the request byte.
- R5: `bus_oe` is high only for RAM writes: from the cycle `wr_en_n` falls, through exactly one cycle after `wr_en_n` rises.
- R6: A read captures `bus_din` at the clock edge that ends the active interval, and shows it on `rd_data`. `rd_data` keeps that value through writes and errors until the next read completes.
- R7: Every executed access lasts 1 setup + N active + 1 end cycles, and is followed by a single-cycle `done` pulse in the next cycle. A new request is accepted in that same cycle.
- R8: A RAM request with any of address bits 18..15 set produces a one-cycle `err` pulse. It causes no pin activity and no `done`, and no RAM data changes.
- R9: A request that arrives while an access is running is ignored; the running access keeps its address and timing.
- R10: `wr_en_n` is never low while `rom_sel_n` is low.
- R11: With default parameters at an 8 ns clock, ACT_RD = max(ceil(500/8), ceil(250/8)) = 63 and ACT_WR = max(ceil(400/8), ceil(200/8), ceil(500/8)-2) = 61.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | One-cycle access request, sampled only when idle |
| req_ram | input | 1 | 1 selects the RAM region, 0 the ROM region |
| req_wr | input | 1 | 1 requests a write (RAM only) |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for a rejected RAM address |
| rd_data | output | 8 | Last captured read byte |
| mem_addr | output | 19 | Device address bus |
| rom_sel_n | output | 1 | ROM chip select, active low |
| shr_sel_n | output | 1 | Shared ROM output enable / RAM chip select, active low |
| wr_en_n | output | 1 | Write enable, active low |
| bus_dout | output | 8 | Data driven toward the device |
| bus_oe | output | 1 | Drive enable for `bus_dout` |
| bus_din | input | 8 | Data returned by the device |

## Verification
The assertions rely on the host issuing requests only as described and holding reset low from time zero. They also rely on `bus_din` being meaningful only while the device is selected for a read. The bench respects both assumptions. It drives requests, and also stray requests during a busy access, only at the falling clock edge, and starts with reset asserted. Its device model returns bytes only when the pins form a valid ROM or RAM read, and returns zero otherwise. It commits a RAM byte on the rising edge of write enable while the ROM select is high.

// File: rtl/combo_mem_ctrl.sv
module combo_mem_ctrl #(
  parameter int CLK_NS  = 8,
  parameter int T_RC_NS = 500,
  parameter int T_OE_NS = 250,
  parameter int T_WP_NS = 400,
  parameter int T_DW_NS = 200,
  parameter int T_WC_NS = 500,
  parameter int AW      = 19,
  parameter int RAM_AW  = 15,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_ram,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          rom_sel_n,
  output logic          shr_sel_n,
  output logic          wr_en_n,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  input  logic [DW-1:0] bus_din
);
  localparam int RC_C   = (T_RC_NS + CLK_NS - 1) / CLK_NS;
  localparam int OE_C   = (T_OE_NS + CLK_NS - 1) / CLK_NS;
  localparam int WP_C   = (T_WP_NS + CLK_NS - 1) / CLK_NS;
  localparam int DW_C   = (T_DW_NS + CLK_NS - 1) / CLK_NS;
  localparam int WC_C   = (T_WC_NS + CLK_NS - 1) / CLK_NS;
  localparam int WC2_C  = (WC_C > 3) ? WC_C - 2 : 1;
  localparam int ACT_RD = (RC_C > OE_C) ? RC_C : OE_C;
  localparam int WPD_C  = (WP_C > DW_C) ? WP_C : DW_C;
  localparam int ACT_WR = (WPD_C > WC2_C) ? WPD_C : WC2_C;
  localparam int ACT_MX = (ACT_RD > ACT_WR) ? ACT_RD : ACT_WR;
  localparam int CW     = $clog2(ACT_MX + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_ACT, S_END} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          ram_q, wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q;

  wire           bad_ram = req_ram && (|req_addr[AW-1:RAM_AW]);
  wire [CW-1:0]  last    = wr_q ? CW'(ACT_WR - 1) : CW'(ACT_RD - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      ram_q   <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wd_q    <= '0;
      rd_data <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE:
          if (req) begin
            if (bad_ram) err <= 1'b1;
            else begin
              ram_q  <= req_ram;
              wr_q   <= req_ram & req_wr;
              addr_q <= req_ram ? {{(AW-RAM_AW){1'b0}}, req_addr[RAM_AW-1:0]} : req_addr;
              wd_q   <= req_wdata;
              st     <= S_SETUP;
            end
          end
        S_SETUP: begin
          cnt <= '0;
          st  <= S_ACT;
        end
        S_ACT:
          if (cnt == last) begin
            if (!wr_q) rd_data <= bus_din;
            st <= S_END;
          end else cnt <= cnt + 1'b1;
        default: begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
      endcase
    end
  end

  assign mem_addr  = addr_q;
  assign bus_dout  = wd_q;
  assign rom_sel_n = !((st == S_SETUP || st == S_ACT) && !ram_q);
  assign shr_sel_n = !(st == S_ACT);
  assign wr_en_n   = !(st == S_ACT && wr_q);
  assign bus_oe    = wr_q && (st == S_ACT || st == S_END);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (rom_sel_n && shr_sel_n && wr_en_n && !bus_oe)); // R1
  AST_OE_AFTER_ROMSEL: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(shr_sel_n) && !rom_sel_n) |-> $past(!rom_sel_n)); // R2
  AST_RAM_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!shr_sel_n && rom_sel_n) |-> (mem_addr[AW-1:RAM_AW] == '0)); // R3
  AST_WRITE_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_n && !$fell(wr_en_n)) |-> $stable(mem_addr) && $stable(bus_dout)); // R4
  AST_DRIVE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (rom_sel_n && (!wr_en_n || $rose(wr_en_n)))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_ERR_NO_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (rom_sel_n && shr_sel_n && !done)); // R8
  AST_NO_WRITE_ON_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_n |-> rom_sel_n); // R10
endmodule

// File: tb/combo_mem_ctrl_tb.sv
module combo_mem_ctrl_tb;
  localparam int ACT_RD = 63; // R11
  localparam int ACT_WR = 61; // R11

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 0, req_ram = 0, req_wr = 0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic done, err, rom_sel_n, shr_sel_n, wr_en_n, bus_oe;
  logic [7:0] rd_data, bus_dout, bus_din;
  logic [18:0] mem_addr;

  always #4 clk = ~clk;

  combo_mem_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_ram(req_ram), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .err(err),
    .rd_data(rd_data), .mem_addr(mem_addr), .rom_sel_n(rom_sel_n),
    .shr_sel_n(shr_sel_n), .wr_en_n(wr_en_n), .bus_dout(bus_dout),
    .bus_oe(bus_oe), .bus_din(bus_din)
  );

  function automatic logic [7:0] rom_byte(input logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'h5A;
  endfunction

  logic [7:0] dev_ram [int];
  logic [7:0] ref_ram [int];

  always @(mem_addr, rom_sel_n, shr_sel_n, wr_en_n) begin
    if (!rom_sel_n && !shr_sel_n) bus_din = rom_byte(mem_addr);
    else if (rom_sel_n && !shr_sel_n && wr_en_n)
      bus_din = dev_ram.exists(int'(mem_addr[14:0])) ? dev_ram[int'(mem_addr[14:0])] : 8'h00;
    else bus_din = 8'h00;
  end

  always @(posedge wr_en_n)
    if (rst_n === 1'b1 && rom_sel_n === 1'b1 && bus_oe === 1'b1)
      dev_ram[int'(mem_addr[14:0])] = bus_dout;

  int compared = 0, mismatched = 0;
  int mt = -1;
  bit mram, mwr, busy_req;
  logic [18:0] maddr;
  logic [7:0] mwd, exp_rdata = 8'h00;
  bit exp_done = 0, exp_err = 0;
  int oe_low = 0;
  bit seen_wr = 0;

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s act=%0h exp=%0h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    int n;
    exp_done = 0; exp_err = 0; busy_req = 0;
    if (!rst_n) begin
      mt = -1; exp_rdata = 8'h00;
    end else if (mt < 0) begin
      if (req) begin
        if (req_ram && req_addr[18:15] != 4'h0) exp_err = 1;
        else begin
          mt = 0; mram = req_ram; mwr = req_ram & req_wr;
          maddr = req_ram ? {4'h0, req_addr[14:0]} : req_addr;
          mwd = req_wdata;
        end
      end
    end else begin
      busy_req = req;
      mt++;
      n = mwr ? ACT_WR : ACT_RD;
      if (mt == n + 1) begin
        if (mwr) ref_ram[int'(maddr[14:0])] = mwd;
        else if (mram) exp_rdata = ref_ram.exists(int'(maddr[14:0])) ? ref_ram[int'(maddr[14:0])] : 8'h00;
        else exp_rdata = rom_byte(maddr);
      end
      if (mt == n + 2) begin mt = -1; exp_done = 1; end
    end
  endtask

  task automatic compare_now();
    int n;
    string tg;
    bit e_rom, e_shr, e_we, e_oe;
    chk(done == exp_done, "R7 done", done, exp_done);
    chk(err == exp_err, "R8 err", err, exp_err);
    chk(rd_data == exp_rdata, "R6 rd_data", rd_data, exp_rdata);
    chk(wr_en_n || rom_sel_n, "R10 write with rom select", {wr_en_n, rom_sel_n}, 2'b11);
    if (mt < 0) begin
      tg = exp_err ? "R8 pins" : "R1 idle pins";
      chk({rom_sel_n, shr_sel_n, wr_en_n, bus_oe} == 4'b1110, tg,
          {rom_sel_n, shr_sel_n, wr_en_n, bus_oe}, 4'b1110);
    end else begin
      n = mwr ? ACT_WR : ACT_RD;
      tg = !mram ? "R2 rom pins" : (mwr ? "R4 write pins" : "R3 ram read pins");
      e_rom = !(mt <= n && !mram);
      e_shr = !(mt >= 1 && mt <= n);
      e_we  = !(mt >= 1 && mt <= n && mwr);
      e_oe  = mwr && mt >= 1;
      chk({rom_sel_n, shr_sel_n, wr_en_n} == {e_rom, e_shr, e_we}, tg,
          {rom_sel_n, shr_sel_n, wr_en_n}, {e_rom, e_shr, e_we});
      chk(mem_addr == maddr, busy_req ? "R9 addr held" : tg, mem_addr, maddr);
      chk(bus_oe == e_oe, "R5 bus_oe", bus_oe, e_oe);
      if (e_oe) chk(bus_dout == mwd, "R4 bus_dout", bus_dout, mwd);
    end
    if (!shr_sel_n) begin
      oe_low++;
      if (!wr_en_n) seen_wr = 1;
    end else if (oe_low > 0) begin
      chk(oe_low == (seen_wr ? ACT_WR : ACT_RD), "R11 active length", oe_low, seen_wr ? ACT_WR : ACT_RD);
      oe_low = 0; seen_wr = 0;
    end
  endtask

  task automatic cyc(input bit rq, input bit rm, input bit w, input logic [18:0] a, input logic [7:0] d);
    req = rq; req_ram = rm; req_wr = w; req_addr = a; req_wdata = d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_now();
  endtask

  task automatic access(input bit rm, input bit w, input logic [18:0] a, input logic [7:0] d, input bit noisy);
    int k = 0;
    cyc(1, rm, w, a, d);
    while (mt >= 0) begin
      k++;
      if (noisy && k < 20) cyc(1, ~rm, ~w, ~a, ~d); // R9: stray requests while busy
      else cyc(0, 0, 0, '0, '0);
    end
    cyc(0, 0, 0, '0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++; compared++;
    $display("FAIL R7 watchdog act=0 exp=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) cyc(0, 0, 0, '0, '0);          // R1 reset state
    rst_n = 1'b1;
    repeat (3) cyc(0, 0, 0, '0, '0);
    access(0, 0, 19'h00000, 8'h00, 0);          // R2
    access(0, 1, 19'h7FFFF, 8'hEE, 0);          // R2 write flag ignored
    access(0, 0, 19'h12345, 8'h00, 0);
    access(1, 1, 19'h00000, 8'hA5, 0);          // R4
    access(1, 1, 19'h07FFF, 8'h3C, 0);
    access(1, 1, 19'h01234, 8'hFF, 1);          // R9 noisy
    access(1, 0, 19'h07FFF, 8'h00, 0);          // R3
    access(1, 0, 19'h00000, 8'h00, 0);
    access(1, 1, 19'h00010, 8'h77, 0);          // R6 rd_data held across write
    access(1, 1, 19'h08000, 8'h99, 0);          // R8 rejected write
    access(1, 0, 19'h40000, 8'h00, 0);          // R8 rejected read
    access(1, 0, 19'h00000, 8'h00, 0);          // R8 location 0 unchanged
    access(1, 0, 19'h01234, 8'h00, 1);
    access(0, 0, 19'h5A5A5, 8'h00, 1);          // R9 on ROM
    // back-to-back: request in the done cycle (R7)
    cyc(1, 1, 0, 19'h00010, 8'h00);
    while (mt >= 0) cyc(0, 0, 0, '0, '0);
    cyc(1, 0, 0, 19'h00ABC, 8'h00);
    while (mt >= 0) cyc(0, 0, 0, '0, '0);
    for (int i = 0; i < 24; i++) begin
      logic [18:0] a;
      logic [7:0]  d;
      bit rm, w;
      a = 19'($urandom); d = 8'($urandom);
      rm = (i % 3) != 0; w = (i % 2) == 0;
      if (rm && (i % 5) != 4) a[18:15] = 4'h0;
      access(rm, w, a, d, (i % 4) == 1);
    end
    repeat (2) cyc(0, 0, 0, '0, '0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule